// File: doc/BRIEF.md
# Rate One-Half Convolutional Encoder

This block turns a serial message into a coded stream. Each message bit that the block accepts produces one two-bit symbol. The block keeps the last three accepted bits in a shift register. Two fixed XOR networks combine the current bit with those three bits, one network for each half of the symbol. The code therefore has memory three and constraint length four.

Input and output both use a valid/ready handshake. The input side carries a last-bit marker. When a bit marked last is taken, the block refuses new input for three cycles. During those cycles it feeds zeros into the register, which brings it back to the all-zero state. The three symbols made this way carry a tail flag. A message sent without the marker is not flushed, so its state carries over into the next bits.

The output symbol sits in a register and stays there until the downstream accepts it. The shift register moves only when an input bit is taken or a flush step runs.

Top module: `conv_enc_r12`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1. All three delay stages are zero.
- R2: `out_sym[1]` is the current bit XOR the bits delayed by two and by three (1+x^2+x^3). `out_sym[0]` is the current bit XOR the bits delayed by one and by three (1+x+x^3). Written as a two-digit string, `out_sym[1]` comes first.
- R3: Every accepted input bit gives exactly one output symbol, in order, with `out_tail` = 0. No symbol appears without a cause.
- R4: A symbol depends on the current bit and the three previously shifted bits. A message that ends without the marker leaves its bits in the register for the next message.
- R5: Taking a bit with `in_last` = 1 starts a flush. Three zero bits are shifted in, which gives three symbols with `out_tail` = 1, and `in_ready` stays 0 while the flush runs.
- R6: After a flush the register is all-zero. The next message encodes exactly as it would after reset.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_sym` and `out_tail` hold their values, and the register does not move.
- R8: Message 1011011 (first bit first) with the marker on its last bit gives the symbols 11, 01, 01, 01, 11, 10, 01, 11, 01, 11. Only the last three of these have `out_tail` = 1.
- R9: `in_bit` and `in_last` have no effect while `in_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input bit present |
| in_ready | output | 1 | Block can take an input bit this cycle |
| in_bit | input | 1 | Message bit |
| in_last | input | 1 | Marks the final bit of a message; starts the flush |
| out_valid | output | 1 | Output symbol present |
| out_ready | input | 1 | Downstream takes the symbol this cycle |
| out_sym | output | 2 | Coded symbol; bit 1 from 1+x^2+x^3, bit 0 from 1+x+x^3 |
| out_tail | output | 1 | Symbol was made by a flush step |

## Verification
The bench builds the block with the package defaults: memory three, the two fixed tap vectors, and a flush length equal to the memory. With these values the fixed reference message, with its ten known symbols, can be compared word for word. Random messages of one to twelve bits are then sent, some flushed and some left open. This exercises state carry-over between messages as well as the return to zero after a flush. Random back-pressure on `out_ready` exercises the hold behaviour and the stall of input during a flush.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;
    // encoder memory (number of unit delays) and symbol width
    localparam int MEM  = 3;
    localparam int NOUT = 2;
    localparam int WIN  = MEM + 1;

    // tap vectors, bit i = coefficient of x^i (delay i)
    // index 1 -> 1 + x^2 + x^3, index 0 -> 1 + x + x^3
    localparam logic [NOUT-1:0][WIN-1:0] TAP_SET = {4'b1101, 4'b1011};

    typedef struct packed {
        logic [MEM-1:0]  hist;   // hist[0] newest, hist[MEM-1] oldest
        logic [NOUT-1:0] sym;
        logic            tail;
        logic            valid;
    } enc_state_t;

    typedef struct packed {
        logic                           busy;
        logic [((MEM > 1) ? $clog2(MEM) : 1)-1:0] cnt;
    } tail_state_t;
endpackage

// File: rtl/conv_enc_parity.sv
module conv_enc_parity #(
    parameter int            MEM  = 3,
    parameter logic [MEM:0]  TAPS = '1
) (
    input  logic           cur,
    input  logic [MEM-1:0] hist,
    output logic           parity
);
    logic [MEM:0] window;

    always_comb begin
        window = {hist, cur};
        parity = ^(window & TAPS);
    end
endmodule

// File: rtl/conv_enc_tail_ctrl.sv
module conv_enc_tail_ctrl
    import conv_enc_pkg::*;
#(
    parameter int STEPS = MEM
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic step,
    output logic busy
);
    localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic          busy_d, busy_q;

    always_comb begin
        cnt_d  = cnt_q;
        busy_d = busy_q;
        if (start) begin
            busy_d = 1'b1;
            cnt_d  = '0;
        end else if (step) begin
            if (cnt_q == CW'(STEPS - 1)) begin
                busy_d = 1'b0;
                cnt_d  = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            busy_q <= busy_d;
        end
    end

    assign busy = busy_q;
endmodule

// File: rtl/conv_enc_r12.sv
module conv_enc_r12
    import conv_enc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic            in_bit,
    input  logic            in_last,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [NOUT-1:0] out_sym,
    output logic            out_tail
);
    enc_state_t      st_d, st_q;
    logic [MEM-1:0]  hist_q;
    logic [NOUT-1:0] par;
    logic            tail_busy;
    logic            slot_free;
    logic            take;
    logic            step;
    logic            cur_bit;

    assign hist_q = st_q.hist;

    // one parity network per symbol bit
    for (genvar g = 0; g < NOUT; g++) begin : g_par
        conv_enc_parity #(
            .MEM  (MEM),
            .TAPS (TAP_SET[g])
        ) i_par (
            .cur    (cur_bit),
            .hist   (st_q.hist),
            .parity (par[g])
        );
    end

    conv_enc_tail_ctrl #(
        .STEPS (MEM)
    ) i_tail (
        .clk   (clk),
        .rst   (rst),
        .start (take && in_last),
        .step  (step),
        .busy  (tail_busy)
    );

    always_comb begin
        slot_free = !st_q.valid || out_ready;
        in_ready  = slot_free && !tail_busy;
        take      = in_valid && in_ready;
        step      = tail_busy && slot_free;
        cur_bit   = take && in_bit;

        st_d = st_q;
        if (take || step) begin
            st_d.hist  = {st_q.hist[MEM-2:0], cur_bit};
            st_d.sym   = par;
            st_d.tail  = step;
            st_d.valid = 1'b1;
        end else if (out_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_sym   = st_q.sym;
    assign out_tail  = st_q.tail;
endmodule

// File: rtl/conv_enc_r12_chk.sv
module conv_enc_r12_chk
    import conv_enc_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic            in_ready,
    input logic            in_last,
    input logic            out_valid,
    input logic            out_ready,
    input logic [NOUT-1:0] out_sym,
    input logic            out_tail,
    input logic            busy,
    input logic [MEM-1:0]  hist
);
    logic [3:0] tail_run;

    always_ff @(posedge clk) begin
        if (rst) tail_run <= '0;
        else if (out_valid && out_ready) tail_run <= out_tail ? tail_run + 1'b1 : '0;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> !out_valid);

    assert_data_symbol_R3: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid && !out_tail);

    assert_flush_blocks_input_R5: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_last |=> !in_ready);

    assert_no_ready_in_flush_R5: assert property (@(posedge clk) disable iff (rst)
        busy |-> !in_ready);

    assert_tail_run_bounded_R5: assert property (@(posedge clk) disable iff (rst)
        tail_run <= 4'(MEM));

    assert_zero_after_flush_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $countones(hist) == 0);

    assert_hold_stall_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_sym) && $stable(out_tail));

    assert_hist_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> $stable(hist));
endmodule

bind conv_enc_r12 conv_enc_r12_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sym   (out_sym),
    .out_tail  (out_tail),
    .busy      (tail_busy),
    .hist      (hist_q)
);

// File: tb/test_conv_enc_r12.sv
module test_conv_enc_r12;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       in_bit = 1'b0;
    logic       in_last = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [1:0] out_sym;
    logic       out_tail;

    always #10 clk = ~clk;   // 50 MHz

    conv_enc_r12 i_conv_enc_r12 (
        .clk, .rst, .in_valid, .in_ready, .in_bit, .in_last,
        .out_valid, .out_ready, .out_sym, .out_tail
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [2:0] exp_q[$];   // {tail, sym}
    logic [2:0] cap[$];
    logic [2:0] mh = 3'b000; // bench model: mh[0] delay1 .. mh[2] delay3
    bit   bp_on = 1'b0;
    bit   hold_pend = 1'b0;
    logic [2:0] hold_val;
    bit   rdy;
    logic [2:0] got;
    logic [2:0] want;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference model from the two polynomials (R2, R4)
    task automatic model_push(input logic u, input logic tl);
        logic a, b;
        a = u ^ mh[1] ^ mh[2];
        b = u ^ mh[0] ^ mh[2];
        exp_q.push_back({tl, a, b});
        mh = {mh[1:0], u};
    endtask

    // monitor / scoreboard, samples at the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            rdy = bp_on ? ($urandom % 4 != 0) : 1'b1;
            out_ready = rdy;
            if (hold_pend)
                chk(out_valid && {out_tail, out_sym} == hold_val, "R7 hold",
                    {out_valid, out_tail, out_sym}, {1'b1, hold_val});
            if (out_valid && rdy) begin
                got = {out_tail, out_sym};
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected symbol", got, 0);
                end else begin
                    want = exp_q.pop_front();
                    chk(got == want, "R2/R3/R4 symbol", got, want);
                end
                cap.push_back(got);
                hold_pend = 1'b0;
            end else if (out_valid) begin
                hold_pend = 1'b1;
                hold_val  = {out_tail, out_sym};
            end else begin
                hold_pend = 1'b0;
            end
        end
    end

    // called at a falling edge
    task automatic send_bit(input logic b, input logic last);
        in_valid = 1'b1;
        in_bit   = b;
        in_last  = last;
        forever begin
            #5;
            if (in_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        model_push(b, 1'b0);
        if (last) begin     // R5: three zero tail steps
            model_push(1'b0, 1'b1);
            model_push(1'b0, 1'b1);
            model_push(1'b0, 1'b1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_bit   = 1'($urandom);   // R9: noise while not valid
        in_last  = 1'($urandom);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b0;
            in_bit   = 1'($urandom);
            in_last  = 1'($urandom);
            @(negedge clk);
        end
    endtask

    task automatic drain;
        while (exp_q.size() != 0) @(negedge clk);
        idle(4);
    endtask

    task automatic run_all;
        logic [6:0] ref_msg;
        logic [1:0] ref_sym[10];
        ref_msg = 7'b1011011;
        ref_sym = '{2'b11, 2'b01, 2'b01, 2'b01, 2'b11, 2'b10, 2'b01, 2'b11, 2'b01, 2'b11};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #5;
        chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
        @(negedge clk);

        // R8 reference message, R9 noise in the gaps
        for (int i = 6; i >= 0; i--) begin
            send_bit(ref_msg[i], i == 0);
            idle(i % 2);
        end
        drain();
        chk(cap.size() == 10, "R8 symbol count", cap.size(), 10);
        for (int i = 0; i < 10; i++)
            chk(cap[i] == {i >= 7, ref_sym[i]}, "R8 reference symbol", cap[i], {i >= 7, ref_sym[i]});

        // R6: after the flush, a single 1 encodes as from reset
        cap.delete();
        send_bit(1'b1, 1'b0);
        drain();
        chk(cap.size() == 1 && cap[0] == 3'b011, "R6 restart from zero", cap[0], 3'b011);

        // R4 carry-over without marker, then back-pressure (R7) and random messages
        bp_on = 1'b1;
        for (int m = 0; m < 30; m++) begin
            int len;
            bit term;
            len  = 1 + ($urandom % 12);
            term = ($urandom % 3) != 0;
            for (int k = 0; k < len; k++) begin
                send_bit(1'($urandom), term && (k == len - 1));
                if ($urandom % 4 == 0) idle(1 + $urandom % 3);
            end
        end
        send_bit(1'b0, 1'b1);
        drain();
        bp_on = 1'b0;
        idle(4);
        chk(exp_q.size() == 0, "R3 scoreboard empty", exp_q.size(), 0);
        chk(out_valid == 1'b0, "R3 no stray symbol", out_valid, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                chk(1'b0, "watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule